// File: doc/BRIEF.md
# Per-Bunch Luminosity Scaler Bank

This block accumulates luminosity statistics separately for every bunch slot of the collider orbit. Each clock cycle is one bunch crossing. In every crossing the block receives a 3-bit hit multiplicity for each of the 16 tubes on detector side A and each of the 16 tubes on side C, a level-1 accept flag, and the orbit marker. It holds four counters per bunch slot, one in each bank. Two banks do event counting: one counts crossings where either side saw a hit, and one counts crossings where both sides did. Two banks do particle counting: one adds the summed multiplicity of all 32 tubes, and one adds that sum only when both sides saw a hit. A separate orbit counter records how many whole orbits were counted, so that the per-slot values can be averaged.

Start and stop requests are held until the next orbit marker. As a result, every bunch slot is integrated over exactly the same set of orbits. Counters change only in crossings that carry a level-1 accept, so detector dead time is already folded into the counts. At the end of a luminosity block the host stops counting, reads each counter through a simple read port, and then starts a new interval. The first orbit of a new interval overwrites the old contents, so no separate clear pass is needed.

Top module: `lumi_bunch_scaler`

## Requirements
- R1: The crossing in which `orbit_i` is high is bunch slot 0. Each following crossing is the next slot. After slot N_SLOTS-1 (default 3564 slots) the count wraps to 0 even without an orbit marker.
- R2: A start or stop pulse takes effect at the first crossing with `orbit_i` high that comes strictly after the pulse. For a start, that crossing is the first one counted. For a stop, that crossing is the first one not counted. `running_o` shows the new state from the following cycle. If start and stop are pulsed in the same cycle, start wins; a later pulse replaces an earlier pending one.
- R3: In the orbit where a start takes effect, every slot counter begins from 0 rather than from its old value. The orbit counter and all overflow flags are also cleared at that orbit marker.
- R4: Counters advance only in counted crossings where `l1a_i` is high. All other crossings leave the stored values unchanged.
- R5: Tube k of a side uses bits [3k+2:3k] of `mult_a_i` or `mult_c_i`. A tube is hit when its value is nonzero. Bank 0 adds 1 when any tube on either side is hit. Bank 1 adds 1 when at least one tube on side A and at least one tube on side C are hit in the same crossing.
- R6: Bank 2 adds the sum of all 32 tube multiplicities. Bank 3 adds the same sum, but only when the bank-1 coincidence condition holds; otherwise it adds 0.
- R7: `orbit_cnt_o` increases by 1 at each orbit marker that closes a counted orbit, including the marker at which a stop takes effect. It changes at no other time, except for the clear in R3.
- R8: Slot counters wrap modulo 2^CNT_W. When an update wraps a counter, `ovf_o[b]` for that bank b is set. The flag stays set until the next start takes effect.
- R9: Two updates to the same slot in consecutive crossings are both accumulated. This happens when orbit markers arrive back to back.
- R10: A read request (`rd_en_i`, `rd_bank_i`, `rd_addr_i`) is accepted only in a cycle where `running_o` is low and no start takes effect. The next cycle then shows `rd_valid_o` high and the selected counter on `rd_data_o`. A request made while counting runs gives no `rd_valid_o`.
- R11: An accepted read with `rd_addr_i` at or above N_SLOTS returns 0 with `rd_valid_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| orbit_i | input | 1 | Orbit marker; high in the crossing of slot 0 |
| l1a_i | input | 1 | Level-1 accept for this crossing |
| start_i | input | 1 | Request to begin counting at the next orbit |
| stop_i | input | 1 | Request to end counting at the next orbit |
| mult_a_i | input | N_TUBES*MW | Side A tube multiplicities, tube k at [3k+2:3k] |
| mult_c_i | input | N_TUBES*MW | Side C tube multiplicities, same packing |
| rd_en_i | input | 1 | Host read request |
| rd_bank_i | input | 2 | Bank select: 0 any-side events, 1 coincident events, 2 hit sum, 3 coincident hit sum |
| rd_addr_i | input | ADDR_W | Bunch slot to read |
| rd_valid_o | output | 1 | Read data valid, one cycle after an accepted request |
| rd_data_o | output | CNT_W | Counter value read |
| running_o | output | 1 | Counting is active |
| orbit_cnt_o | output | ORBIT_W | Number of completed counted orbits |
| ovf_o | output | 4 | Sticky wrap flag per bank |

## Verification
Several properties are checked by assertions on every cycle. The slot number stays in range and returns to zero after an orbit marker. The run state and the orbit counter change only at orbit markers. Event increments never exceed one, and coincidence increments never exceed their plain counterparts. Overflow flags drop only when a start clears them, and read data never appears while counting runs. The bench scenarios are needed for the remaining behaviour: the per-slot accumulated values under accepted and rejected crossings, the clearing of old contents in the first orbit of a new interval, the accumulation through forwarding when orbit markers arrive back to back, start-over-stop priority, and counter wrap with its flags.

// File: rtl/lumi_pkg.sv
package lumi_pkg;

    // Number of scaler banks kept per bunch slot
    localparam int NBANK = 4;

    // Bank indices; the host read port decodes these values
    localparam int BANK_EVT_ANY   = 0;
    localparam int BANK_EVT_COINC = 1;
    localparam int BANK_HIT_ANY   = 2;
    localparam int BANK_HIT_COINC = 3;

    localparam int BANK_SEL_W = $clog2(NBANK);

endpackage

// File: rtl/lumi_run_ctrl.sv
module lumi_run_ctrl #(
    parameter int N_SLOTS = 3564,
    parameter int SLOT_W  = $clog2(N_SLOTS),
    parameter int ORBIT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               orbit_i,
    input  logic               start_i,
    input  logic               stop_i,
    output logic [SLOT_W-1:0]  slot_o,
    output logic               run_o,
    output logic               fresh_o,
    output logic               clear_o,
    output logic               running_o,
    output logic [ORBIT_W-1:0] orbit_cnt_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic               run;
        logic               fresh;
        logic               start_pend;
        logic               stop_pend;
        logic [ORBIT_W-1:0] orbits;
    } ctrl_t;

    ctrl_t st_q, st_d;

    logic              at_last;
    logic [SLOT_W-1:0] slot_cur;
    logic              run_cur;
    logic              fresh_cur;
    logic              clear_cur;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.slot == LAST_SLOT);

        // Slot of the present crossing
        if (orbit_i || at_last) begin
            slot_cur = '0;
        end else begin
            slot_cur = st_q.slot + SLOT_W'(1);
        end

        // Run state and first-orbit marker for the present crossing
        run_cur   = st_q.run;
        fresh_cur = at_last ? 1'b0 : st_q.fresh;
        clear_cur = 1'b0;
        if (orbit_i) begin
            if (st_q.start_pend) begin
                run_cur = 1'b1;
            end else if (st_q.stop_pend) begin
                run_cur = 1'b0;
            end
            fresh_cur = st_q.start_pend;
            clear_cur = st_q.start_pend;
        end

        st_d.slot  = slot_cur;
        st_d.run   = run_cur;
        st_d.fresh = fresh_cur && run_cur;

        // Completed-orbit counter
        if (clear_cur) begin
            st_d.orbits = '0;
        end else if (orbit_i && st_q.run) begin
            st_d.orbits = st_q.orbits + ORBIT_W'(1);
        end

        // Pending requests: newest wins, start beats stop in one cycle
        if (start_i) begin
            st_d.start_pend = 1'b1;
            st_d.stop_pend  = 1'b0;
        end else if (stop_i) begin
            st_d.start_pend = 1'b0;
            st_d.stop_pend  = 1'b1;
        end else if (orbit_i) begin
            st_d.start_pend = 1'b0;
            st_d.stop_pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.slot <= LAST_SLOT;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o      = slot_cur;
    assign run_o       = run_cur;
    assign fresh_o     = fresh_cur;
    assign clear_o     = clear_cur;
    assign running_o   = st_q.run;
    assign orbit_cnt_o = st_q.orbits;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= LAST_SLOT);                                     // R1
    AST_SLOT_ORBIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        orbit_i |=> (st_q.slot == '0));                              // R1
    AST_RUN_AT_ORBIT: assert property (@(posedge clk) disable iff (!rst_n)
        !orbit_i |=> $stable(st_q.run));                             // R2
    AST_ORBIT_CNT_AT_ORBIT: assert property (@(posedge clk) disable iff (!rst_n)
        !orbit_i |=> $stable(st_q.orbits));                          // R7

endmodule

// File: rtl/lumi_hit_reduce.sv
module lumi_hit_reduce
    import lumi_pkg::*;
#(
    parameter int N_TUBES = 16,
    parameter int MW      = 3,
    parameter int INC_W   = 8
) (
    input  logic [N_TUBES*MW-1:0]          mult_a_i,
    input  logic [N_TUBES*MW-1:0]          mult_c_i,
    output logic [NBANK-1:0][INC_W-1:0]    inc_o
);

    logic [N_TUBES-1:0] hit_a;
    logic [N_TUBES-1:0] hit_c;

    // One hit flag per tube and side
    for (genvar k = 0; k < N_TUBES; k++) begin : g_tube
        assign hit_a[k] = |mult_a_i[k*MW +: MW];
        assign hit_c[k] = |mult_c_i[k*MW +: MW];
    end

    logic [INC_W-1:0] hit_sum;
    logic             side_any;
    logic             side_both;

    always_comb begin
        hit_sum = '0;
        for (int k = 0; k < N_TUBES; k++) begin
            hit_sum = hit_sum + INC_W'(mult_a_i[k*MW +: MW])
                              + INC_W'(mult_c_i[k*MW +: MW]);
        end
        side_any  = (|hit_a) || (|hit_c);
        side_both = (|hit_a) && (|hit_c);

        inc_o                 = '0;
        inc_o[BANK_EVT_ANY]   = INC_W'(side_any);
        inc_o[BANK_EVT_COINC] = INC_W'(side_both);
        inc_o[BANK_HIT_ANY]   = hit_sum;
        inc_o[BANK_HIT_COINC] = side_both ? hit_sum : '0;
    end

endmodule

// File: rtl/lumi_count_ram.sv
module lumi_count_ram #(
    parameter int DEPTH  = 3564,
    parameter int WORD_W = 128,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i
);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] rdata_q;

    // Synchronous read returns the contents before a same-edge write
    always_ff @(posedge clk) begin
        if (re_i) begin
            rdata_q <= mem_q[raddr_i];
        end
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/lumi_bunch_scaler.sv
module lumi_bunch_scaler
    import lumi_pkg::*;
#(
    parameter int N_SLOTS = 3564,
    parameter int N_TUBES = 16,
    parameter int MW      = 3,
    parameter int CNT_W   = 32,
    parameter int ORBIT_W = 32,
    parameter int ADDR_W  = $clog2(N_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  orbit_i,
    input  logic                  l1a_i,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic [N_TUBES*MW-1:0] mult_a_i,
    input  logic [N_TUBES*MW-1:0] mult_c_i,
    input  logic                  rd_en_i,
    input  logic [1:0]            rd_bank_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic                  rd_valid_o,
    output logic [CNT_W-1:0]      rd_data_o,
    output logic                  running_o,
    output logic [ORBIT_W-1:0]    orbit_cnt_o,
    output logic [NBANK-1:0]      ovf_o
);

    localparam int INC_W  = MW + $clog2(N_TUBES) + 1;
    localparam int WORD_W = NBANK * CNT_W;

    // ---------------- crossing sequencing ----------------
    logic [ADDR_W-1:0] slot_cur;
    logic              run_cur;
    logic              fresh_cur;
    logic              ovf_clr;

    lumi_run_ctrl #(
        .N_SLOTS (N_SLOTS),
        .SLOT_W  (ADDR_W),
        .ORBIT_W (ORBIT_W)
    ) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .orbit_i     (orbit_i),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .slot_o      (slot_cur),
        .run_o       (run_cur),
        .fresh_o     (fresh_cur),
        .clear_o     (ovf_clr),
        .running_o   (running_o),
        .orbit_cnt_o (orbit_cnt_o)
    );

    // ---------------- per-crossing increments ----------------
    logic [NBANK-1:0][INC_W-1:0] inc_w;

    lumi_hit_reduce #(
        .N_TUBES (N_TUBES),
        .MW      (MW),
        .INC_W   (INC_W)
    ) u_hits (
        .mult_a_i (mult_a_i),
        .mult_c_i (mult_c_i),
        .inc_o    (inc_w)
    );

    // ---------------- accumulate pipeline state ----------------
    typedef struct packed {
        logic                        valid;
        logic                        fresh;
        logic [ADDR_W-1:0]           addr;
        logic [NBANK-1:0][INC_W-1:0] inc;
    } upd_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wlast_t;

    typedef struct packed {
        upd_t                  upd;
        wlast_t                wl;
        logic [NBANK-1:0]      ovf;
        logic                  rd_valid;
        logic [BANK_SEL_W-1:0] rd_bank;
        logic                  rd_zero;
    } acc_t;

    acc_t acc_q, acc_d;

    logic              ram_re;
    logic [ADDR_W-1:0] ram_raddr;
    logic [WORD_W-1:0] ram_rdata;
    logic              ram_we;
    logic [WORD_W-1:0] ram_wdata;
    logic              fwd_hit;
    logic              rd_accept;
    logic              rd_oor;
    logic [CNT_W-1:0]  base;
    logic [CNT_W:0]    total;
    logic [NBANK-1:0]  carry;

    always_comb begin
        acc_d = acc_q;

        // Stage A: capture the crossing and issue the memory read
        acc_d.upd.valid = run_cur;
        acc_d.upd.fresh = fresh_cur;
        acc_d.upd.addr  = slot_cur;
        for (int b = 0; b < NBANK; b++) begin
            acc_d.upd.inc[b] = l1a_i ? inc_w[b] : '0;
        end

        rd_oor    = (rd_addr_i >= ADDR_W'(N_SLOTS));
        rd_accept = rd_en_i && !run_cur && !running_o;
        ram_re    = run_cur || (rd_accept && !rd_oor);
        ram_raddr = run_cur ? slot_cur : rd_addr_i;

        // Stage B: add, with the previous write forwarded on a same-slot hit
        fwd_hit   = acc_q.wl.valid && (acc_q.wl.addr == acc_q.upd.addr);
        ram_wdata = '0;
        carry     = '0;
        base      = '0;
        total     = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (acc_q.upd.fresh) begin
                base = '0;
            end else if (fwd_hit) begin
                base = acc_q.wl.data[b*CNT_W +: CNT_W];
            end else begin
                base = ram_rdata[b*CNT_W +: CNT_W];
            end
            total    = {1'b0, base} + (CNT_W+1)'(acc_q.upd.inc[b]);
            carry[b] = total[CNT_W];
            ram_wdata[b*CNT_W +: CNT_W] = total[CNT_W-1:0];
        end
        ram_we = acc_q.upd.valid;

        acc_d.wl.valid = acc_q.upd.valid;
        acc_d.wl.addr  = acc_q.upd.addr;
        acc_d.wl.data  = ram_wdata;

        if (ovf_clr) begin
            acc_d.ovf = '0;
        end else if (acc_q.upd.valid) begin
            acc_d.ovf = acc_q.ovf | carry;
        end

        // Host read bookkeeping for the data mux
        acc_d.rd_valid = rd_accept;
        acc_d.rd_bank  = rd_bank_i;
        acc_d.rd_zero  = rd_oor;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    lumi_count_ram #(
        .DEPTH  (N_SLOTS),
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk     (clk),
        .re_i    (ram_re),
        .raddr_i (ram_raddr),
        .rdata_o (ram_rdata),
        .we_i    (ram_we),
        .waddr_i (acc_q.upd.addr),
        .wdata_i (ram_wdata)
    );

    assign rd_valid_o = acc_q.rd_valid;
    assign rd_data_o  = (acc_q.rd_valid && !acc_q.rd_zero)
                      ? ram_rdata[acc_q.rd_bank*CNT_W +: CNT_W] : '0;
    assign ovf_o      = acc_q.ovf;

    AST_EVT_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        inc_w[BANK_EVT_ANY] <= INC_W'(1));                           // R5
    AST_EVT_COINC_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        inc_w[BANK_EVT_COINC] <= inc_w[BANK_EVT_ANY]);               // R5
    AST_HIT_COINC_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        inc_w[BANK_HIT_COINC] <= inc_w[BANK_HIT_ANY]);               // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_clr |=> ((acc_q.ovf & $past(acc_q.ovf)) == $past(acc_q.ovf))); // R8
    AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !running_o);                                  // R10
    AST_NO_READ_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && rd_en_i) |=> !rd_valid_o);                     // R10

endmodule

// File: tb/lumi_bunch_scaler_tb.sv
module lumi_bunch_scaler_tb;

    localparam int N_SLOTS = 12;
    localparam int N_TUBES = 16;
    localparam int MW      = 3;
    localparam int CNT_W   = 12;
    localparam int ORBIT_W = 32;
    localparam int ADDR_W  = $clog2(N_SLOTS);
    localparam int MV_W    = N_TUBES * MW;
    localparam int MODV    = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              orbit_i = 1'b0, l1a_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
    logic [MV_W-1:0]   mult_a_i = '0, mult_c_i = '0;
    logic              rd_en_i = 1'b0;
    logic [1:0]        rd_bank_i = '0;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic              rd_valid_o;
    logic [CNT_W-1:0]  rd_data_o;
    logic              running_o;
    logic [ORBIT_W-1:0] orbit_cnt_o;
    logic [3:0]        ovf_o;

    always #2 clk = ~clk;

    lumi_bunch_scaler #(
        .N_SLOTS (N_SLOTS), .N_TUBES (N_TUBES), .MW (MW),
        .CNT_W (CNT_W), .ORBIT_W (ORBIT_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .orbit_i (orbit_i), .l1a_i (l1a_i),
        .start_i (start_i), .stop_i (stop_i), .mult_a_i (mult_a_i),
        .mult_c_i (mult_c_i), .rd_en_i (rd_en_i), .rd_bank_i (rd_bank_i),
        .rd_addr_i (rd_addr_i), .rd_valid_o (rd_valid_o), .rd_data_o (rd_data_o),
        .running_o (running_o), .orbit_cnt_o (orbit_cnt_o), .ovf_o (ovf_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Stimulus for the next crossing
    bit              d_orb, d_l1a, d_start, d_stop, d_rd;
    logic [1:0]      d_bank;
    logic [ADDR_W-1:0] d_addr;
    logic [MV_W-1:0] d_a, d_c;

    // Reference model state
    int unsigned m_cnt [4][N_SLOTS];
    bit [3:0]    m_ovf;
    int unsigned m_orbits;
    int          m_slot;
    bit          m_run, m_fresh, m_sp, m_stp;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit side_hit(input logic [MV_W-1:0] v);
        bit h = 0;
        for (int k = 0; k < N_TUBES; k++) if (v[k*MW +: MW] != 0) h = 1;
        return h;
    endfunction

    function automatic int unsigned tube_sum(input logic [MV_W-1:0] a, input logic [MV_W-1:0] c);
        int unsigned s = 0;
        for (int k = 0; k < N_TUBES; k++) s += a[k*MW +: MW] + c[k*MW +: MW];
        return s;
    endfunction

    function automatic int unsigned bank_inc(input int b, input logic [MV_W-1:0] a,
                                             input logic [MV_W-1:0] c);
        bit any  = side_hit(a) || side_hit(c);
        bit both = side_hit(a) && side_hit(c);
        case (b)
            0:       return any ? 1 : 0;
            1:       return both ? 1 : 0;
            2:       return tube_sum(a, c);
            default: return both ? tube_sum(a, c) : 0;
        endcase
    endfunction

    task automatic model_step();
        int  slot;
        bit  run_now, fr;
        slot    = d_orb ? 0 : ((m_slot == N_SLOTS-1) ? 0 : m_slot + 1);
        run_now = d_orb ? (m_sp ? 1'b1 : (m_stp ? 1'b0 : m_run)) : m_run;
        fr      = d_orb ? m_sp : ((m_slot == N_SLOTS-1) ? 1'b0 : m_fresh);
        if (d_orb) begin
            if (m_sp) begin
                m_orbits = 0;
                m_ovf    = '0;
            end else if (m_run) begin
                m_orbits++;
            end
        end
        if (run_now) begin
            for (int b = 0; b < 4; b++) begin
                int unsigned s;
                s = (fr ? 0 : m_cnt[b][slot]) + (d_l1a ? bank_inc(b, d_a, d_c) : 0);
                if (s >= MODV) begin
                    m_ovf[b] = 1'b1;
                    s = s - MODV;
                end
                m_cnt[b][slot] = s;
            end
        end
        m_slot  = slot;
        m_run   = run_now;
        m_fresh = fr && run_now;
        if (d_start) begin
            m_sp = 1; m_stp = 0;
        end else if (d_stop) begin
            m_sp = 0; m_stp = 1;
        end else if (d_orb) begin
            m_sp = 0; m_stp = 0;
        end
    endtask

    task automatic step();
        @(negedge clk);
        orbit_i = d_orb; l1a_i = d_l1a; start_i = d_start; stop_i = d_stop;
        mult_a_i = d_a; mult_c_i = d_c;
        rd_en_i = d_rd; rd_bank_i = d_bank; rd_addr_i = d_addr;
        model_step();
        @(posedge clk);
        #1;
        d_orb = 0; d_l1a = 0; d_start = 0; d_stop = 0; d_rd = 0;
        d_a = '0; d_c = '0;
    endtask

    function automatic logic [MV_W-1:0] rand_side();
        logic [MV_W-1:0] v = '0;
        for (int k = 0; k < N_TUBES; k++)
            if ($urandom % 4 == 0) v[k*MW +: MW] = MW'($urandom);
        return v;
    endfunction

    // kind 0: random, 1: no accepts, 2: side A only, 3: all tubes at maximum
    task automatic run_orbits(input int n, input int kind, input bit probe);
        for (int o = 0; o < n; o++) begin
            for (int s = 0; s < N_SLOTS; s++) begin
                d_orb = (s == 0);
                case (kind)
                    0: begin
                        int m = $urandom % 4;
                        d_l1a = ($urandom % 3 != 0);
                        d_a = (m == 1 || m == 3) ? rand_side() : '0;
                        d_c = (m == 2 || m == 3) ? rand_side() : '0;
                    end
                    1: begin d_l1a = 0; d_a = rand_side(); d_c = rand_side(); end
                    2: begin d_l1a = 1; d_a = rand_side(); d_c = '0; end
                    default: begin d_l1a = 1; d_a = '1; d_c = '1; end
                endcase
                if (probe && s == 3) begin
                    d_rd = 1; d_bank = 2'd2; d_addr = '0;
                end
                step();
                if (probe && s == 3) check("R10 read while running", 64'(rd_valid_o), 64'd0);
            end
        end
    endtask

    task automatic stop_now();
        d_stop = 1; step();
        d_orb = 1; step();
        step();
    endtask

    task automatic read_all(input string tag);
        for (int b = 0; b < 4; b++) begin
            for (int s = 0; s < N_SLOTS; s++) begin
                d_rd = 1; d_bank = 2'(b); d_addr = ADDR_W'(s);
                step();
                check({tag, " valid"}, 64'(rd_valid_o), 64'd1);
                check(tag, 64'(rd_data_o), 64'(m_cnt[b][s]));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        d_orb = 0; d_l1a = 0; d_start = 0; d_stop = 0; d_rd = 0;
        d_bank = '0; d_addr = '0; d_a = '0; d_c = '0;
        m_ovf = '0; m_orbits = 0; m_slot = N_SLOTS-1;
        m_run = 0; m_fresh = 0; m_sp = 0; m_stp = 0;
        for (int b = 0; b < 4; b++) for (int s = 0; s < N_SLOTS; s++) m_cnt[b][s] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R2 reset running", 64'(running_o), 64'd0);
        check("R7 reset orbit count", 64'(orbit_cnt_o), 64'd0);
        check("R8 reset overflow", 64'(ovf_o), 64'd0);
        check("R10 reset read valid", 64'(rd_valid_o), 64'd0);

        // Start is held until an orbit marker
        step(); d_start = 1; step(); step(); step();
        check("R2 start waits for orbit", 64'(running_o), 64'd0);
        d_orb = 1; d_l1a = 1; d_a = rand_side(); d_c = rand_side(); step();
        check("R2 start at orbit", 64'(running_o), 64'd1);
        for (int s = 1; s < N_SLOTS; s++) begin
            d_l1a = 1; d_a = rand_side(); d_c = rand_side(); step();
        end
        run_orbits(2, 0, 1'b0);
        run_orbits(1, 0, 1'b1);
        // One orbit without a marker: slot wraps by itself (R1)
        for (int s = 0; s < N_SLOTS; s++) begin
            d_l1a = 1; d_a = rand_side(); d_c = rand_side(); step();
        end
        run_orbits(1, 0, 1'b0);
        d_stop = 1; step();
        check("R2 stop waits for orbit", 64'(running_o), 64'd1);
        d_orb = 1; d_l1a = 1; d_a = '1; d_c = '1; step();
        check("R2 stop at orbit", 64'(running_o), 64'd0);
        check("R7 orbit count", 64'(orbit_cnt_o), 64'(m_orbits));
        check("R7 orbit count literal", 64'(orbit_cnt_o), 64'd5);
        step();
        read_all("R1 R4 R5 R6 readback");
        d_rd = 1; d_bank = 2'd2; d_addr = ADDR_W'(N_SLOTS + 1); step();
        check("R11 out of range valid", 64'(rd_valid_o), 64'd1);
        check("R11 out of range data", 64'(rd_data_o), 64'd0);

        // Start and stop together: start wins; side A only leaves coincidence banks at 0
        d_start = 1; d_stop = 1; step();
        d_orb = 1; d_l1a = 1; d_a = rand_side(); step();
        check("R2 start beats stop", 64'(running_o), 64'd1);
        for (int s = 1; s < N_SLOTS; s++) begin
            d_l1a = 1; d_a = rand_side(); step();
        end
        run_orbits(1, 2, 1'b0);
        stop_now();
        d_rd = 1; d_bank = 2'd1; d_addr = '0; step();
        check("R5 coincidence zero with one side", 64'(rd_data_o), 64'd0);
        read_all("R3 R5 R6 single side");

        // No accepts: counters restart from zero and stay there
        d_start = 1; step();
        run_orbits(2, 1, 1'b0);
        stop_now();
        read_all("R3 R4 no accept");

        // Back-to-back orbit markers hit slot 0 twice
        d_start = 1; step();
        d_orb = 1; d_l1a = 1; d_a = rand_side(); d_c = rand_side(); step();
        d_orb = 1; d_l1a = 1; d_a = '1; d_c = '1; step();
        for (int s = 1; s < N_SLOTS; s++) begin
            d_l1a = 1; d_a = rand_side(); d_c = rand_side(); step();
        end
        d_orb = 1; d_l1a = 1; d_a = '1; d_c = rand_side(); step();
        d_orb = 1; d_l1a = 1; d_a = rand_side(); d_c = '1; step();
        run_orbits(1, 0, 1'b0);
        stop_now();
        d_rd = 1; d_bank = 2'd2; d_addr = '0; step();
        check("R9 same slot accumulate", 64'(rd_data_o), 64'(m_cnt[2][0]));
        read_all("R9 back to back");

        // Wrap of the particle banks
        d_start = 1; step();
        run_orbits(20, 3, 1'b0);
        stop_now();
        check("R8 overflow flags", 64'(ovf_o), 64'hC);
        check("R8 overflow model", 64'(ovf_o), 64'(m_ovf));
        step(); step();
        check("R8 overflow sticky", 64'(ovf_o), 64'hC);
        read_all("R8 wrapped values");
        d_start = 1; step();
        d_orb = 1; step();
        check("R3 overflow cleared", 64'(ovf_o), 64'd0);
        check("R3 orbit count cleared", 64'(orbit_cnt_o), 64'd0);
        for (int s = 1; s < N_SLOTS; s++) step();
        stop_now();
        check("R7 single orbit count", 64'(orbit_cnt_o), 64'd1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule